// File: doc/BRIEF.md
# Exception Entry Stack Frame Sequencer

This block writes the return frame that a processor core needs when it enters an interrupt or exception handler through an interrupt gate or a trap gate. The core presents a one-cycle request with the gate kind, the live SS, ESP, EFLAGS, CS and EIP, and an optional error code. If the entry raises privilege, the core also presents the handler's stack selector and pointer. The block then issues one 32-bit store per accepted memory handshake, working downward from the chosen stack pointer. When the last store is accepted it reports the final stack pointer, the stack selector in force and the flags value with the trace and interrupt-enable bits adjusted.

A request through a task gate, or any other gate kind, does not fit this frame scheme. The block answers it with a one-cycle unsupported pulse and issues no stores. Selector decoding, descriptor fetches, privilege checks and the return path belong to neighbouring logic.

Top module: `exc_frame_seq`

## Requirements
- R1: After a synchronous active-low reset, `wr_valid`, `busy`, `done` and `unsupported` are all low.
- R2: With `priv_change` low, the frame goes on the current stack as EFLAGS, then CS, then EIP, at `cur_esp-4`, `cur_esp-8` and `cur_esp-12`. Each push first steps the pointer down by 4 and then writes at the new pointer.
- R3: With `priv_change` high, the pushes start from `new_esp` and the order is old SS, old ESP, EFLAGS, CS, EIP. The first push goes to `new_esp-4`.
- R4: With `err_present` high, `err_code` is pushed after EIP, so it is the lowest-addressed word of the frame. The frame therefore holds 3, 4, 5 or 6 words.
- R5: Each 16-bit selector (CS, SS) fills a 32-bit slot with the selector in bits 15:0 and zeros in bits 31:16.
- R6: A store is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, `wr_addr` and `wr_data` hold their values.
- R7: `done` is high for exactly one cycle, in the cycle after the final store is accepted. In that cycle `done_esp` equals the address of the final store, and `done_ss` is `new_ss` when `priv_change` was set and `cur_ss` otherwise.
- R8: The stored EFLAGS word is the unmodified input. `done_eflags` has TF (bit 8) cleared for both gate kinds. It also has IF (bit 9) cleared for an interrupt gate (`gate_kind`=0), while a trap gate (`gate_kind`=1) leaves IF as it was.
- R9: A task gate (`gate_kind`=2) or the reserved code 3 produces a one-cycle `unsupported` pulse in the cycle after the request, with no store and no `done`.
- R10: While `busy` is high, `req_valid` is ignored, so no extra store and no extra `done` follow.
- R11: Reset in the middle of a frame drops `wr_valid` and `busy` at the next edge and abandons the rest of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Entry request strobe, sampled only when idle |
| gate_kind | input | 2 | 0 interrupt gate, 1 trap gate, 2 task gate, 3 reserved |
| err_present | input | 1 | Entry carries an error code |
| err_code | input | 32 | Error code word |
| priv_change | input | 1 | Entry switches to a more privileged stack |
| cur_ss | input | 16 | Current stack selector |
| cur_esp | input | 32 | Current stack pointer |
| cur_eflags | input | 32 | Current flags |
| cur_cs | input | 16 | Current code selector |
| cur_eip | input | 32 | Return instruction pointer |
| new_ss | input | 16 | Handler stack selector, used on privilege change |
| new_esp | input | 32 | Handler stack pointer, used on privilege change |
| busy | output | 1 | A frame is being written |
| wr_valid | output | 1 | Store request to the memory port |
| wr_ready | input | 1 | Memory port accepts the store |
| wr_addr | output | 32 | Store byte address |
| wr_data | output | 32 | Store data word |
| done | output | 1 | One-cycle completion pulse |
| done_esp | output | 32 | Final stack pointer, valid with `done` |
| done_ss | output | 16 | Stack selector in force, valid with `done` |
| done_eflags | output | 32 | Flags after entry, valid with `done` |
| unsupported | output | 1 | One-cycle pulse for a gate kind this block does not serve |

## Verification
A request sampled at a clock edge raises `wr_valid` for the first word right after that edge. Each following word appears right after the edge that accepts the one before it. `done`, together with its result fields, follows one cycle after the final accepted store, and `unsupported` follows one cycle after a rejected request. The bench changes inputs on the falling edge and samples one nanosecond later. A store seen with both `wr_valid` and `wr_ready` high at that point is taken from the expected queue, because it completes at the next rising edge, so every result is compared in the cycle it is due.

// File: rtl/efr_pkg.sv
// Shared widths, codes and types for the exception entry frame sequencer.
// Assumes a 32-bit stack slot and 16-bit segment selectors.
package efr_pkg;
    localparam int WORD_W     = 32;
    localparam int SEL_W      = 16;
    localparam int SLOT_BYTES = WORD_W / 8;
    localparam int SLOT_IDX_W = 3;

    typedef enum logic [1:0] {
        GATE_INTR = 2'd0,
        GATE_TRAP = 2'd1,
        GATE_TASK = 2'd2,
        GATE_RSVD = 2'd3
    } gate_e;

    // Logical frame slots, in push order; a frame is a contiguous run of them.
    typedef enum logic [SLOT_IDX_W-1:0] {
        SLOT_SS    = 3'd0,
        SLOT_ESP   = 3'd1,
        SLOT_FLAGS = 3'd2,
        SLOT_CS    = 3'd3,
        SLOT_EIP   = 3'd4,
        SLOT_ERR   = 3'd5
    } slot_e;

    typedef enum logic {ST_IDLE, ST_PUSH} seq_st_e;

    typedef struct packed {
        logic [SEL_W-1:0]  ss;
        logic [WORD_W-1:0] esp;
        logic [WORD_W-1:0] eflags;
        logic [SEL_W-1:0]  cs;
        logic [WORD_W-1:0] eip;
        logic [WORD_W-1:0] err;
    } entry_ctx_t;
endpackage

// File: rtl/efr_word_mux.sv
// Selects the stack word for one logical frame slot.
// Assumes selectors are narrower than a word; they are zero-extended.
module efr_word_mux
    import efr_pkg::*;
(
    input  entry_ctx_t        ctx,
    input  slot_e             slot,
    output logic [WORD_W-1:0] word
);
    localparam int PAD_W = WORD_W - SEL_W;

    // Map the slot code onto its context field.
    always_comb begin
        case (slot)
            SLOT_SS:    word = {{PAD_W{1'b0}}, ctx.ss};
            SLOT_ESP:   word = ctx.esp;
            SLOT_FLAGS: word = ctx.eflags;
            SLOT_CS:    word = {{PAD_W{1'b0}}, ctx.cs};
            SLOT_EIP:   word = ctx.eip;
            SLOT_ERR:   word = ctx.err;
            default:    word = '0;
        endcase
    end
endmodule

// File: rtl/efr_flag_mask.sv
// Produces the live flags after gate entry: trace bit always cleared,
// interrupt-enable bit cleared only for an interrupt gate.
// Assumes both bit positions lie inside the word.
module efr_flag_mask
    import efr_pkg::*;
#(
    parameter int TF_POS = 8,
    parameter int IF_POS = 9
) (
    input  logic [WORD_W-1:0] flags_in,
    input  logic              is_intr_gate,
    output logic [WORD_W-1:0] flags_out
);
    localparam logic [WORD_W-1:0] TF_MASK = WORD_W'(1) << TF_POS;
    localparam logic [WORD_W-1:0] IF_MASK = WORD_W'(1) << IF_POS;

    // Clear the trace bit, and the interrupt-enable bit for interrupt gates.
    always_comb begin
        flags_out = flags_in & ~TF_MASK;
        if (is_intr_gate)
            flags_out = flags_out & ~IF_MASK;
    end
endmodule

// File: rtl/exc_frame_seq.sv
// Exception entry stack frame sequencer.
// On an accepted request it captures the entry context, picks the stack
// (current or handler), and pushes 3 to 6 words downward, one per memory
// handshake. Each push steps the pointer by one slot before the write.
// Assumes a request is a one-cycle strobe; it is only sampled while idle.
module exc_frame_seq
    import efr_pkg::*;
#(
    parameter int TF_POS = 8,
    parameter int IF_POS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        gate_kind,
    input  logic              err_present,
    input  logic [WORD_W-1:0] err_code,
    input  logic              priv_change,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [WORD_W-1:0] cur_esp,
    input  logic [WORD_W-1:0] cur_eflags,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [WORD_W-1:0] cur_eip,
    input  logic [SEL_W-1:0]  new_ss,
    input  logic [WORD_W-1:0] new_esp,
    output logic              busy,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic [WORD_W-1:0] done_esp,
    output logic [SEL_W-1:0]  done_ss,
    output logic [WORD_W-1:0] done_eflags,
    output logic              unsupported
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(SLOT_BYTES);

    seq_st_e           st_q;
    entry_ctx_t        ctx_q;
    logic [WORD_W-1:0] sp_q;
    logic [SEL_W-1:0]  stk_sel_q;
    slot_e             slot_q;
    slot_e             last_q;
    logic              intr_q;
    logic              done_q;
    logic              unsup_q;
    gate_e             gate;
    logic              gate_ok;
    logic              take;
    logic              push_acc;
    logic [WORD_W-1:0] push_word;

    assign gate     = gate_e'(gate_kind);
    assign gate_ok  = (gate == GATE_INTR) || (gate == GATE_TRAP);
    assign take     = (st_q == ST_IDLE) && req_valid;
    assign push_acc = (st_q == ST_PUSH) && wr_ready;

    // Sequencer state, done pulse and unsupported pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            unsup_q <= take && !gate_ok;
            if (take && gate_ok)
                st_q <= ST_PUSH;
            else if (push_acc && (slot_q == last_q)) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
            end
        end
    end

    // Capture entry context and frame bounds when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q     <= '0;
            stk_sel_q <= '0;
            last_q    <= SLOT_EIP;
            intr_q    <= 1'b0;
        end else if (take && gate_ok) begin
            ctx_q     <= '{ss: cur_ss, esp: cur_esp, eflags: cur_eflags,
                           cs: cur_cs, eip: cur_eip, err: err_code};
            stk_sel_q <= priv_change ? new_ss : cur_ss;
            last_q    <= err_present ? SLOT_ERR : SLOT_EIP;
            intr_q    <= (gate == GATE_INTR);
        end
    end

    // Stack pointer and current slot: load on entry, advance per push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q   <= '0;
            slot_q <= SLOT_SS;
        end else if (take && gate_ok) begin
            sp_q   <= priv_change ? new_esp : cur_esp;
            slot_q <= priv_change ? SLOT_SS : SLOT_FLAGS;
        end else if (push_acc) begin
            sp_q <= wr_addr;
            if (slot_q != last_q)
                slot_q <= slot_e'(slot_q + 3'd1);
        end
    end

    efr_word_mux u_mux (
        .ctx  (ctx_q),
        .slot (slot_q),
        .word (push_word)
    );

    efr_flag_mask #(.TF_POS(TF_POS), .IF_POS(IF_POS)) u_flags (
        .flags_in     (ctx_q.eflags),
        .is_intr_gate (intr_q),
        .flags_out    (done_eflags)
    );

    assign busy        = (st_q == ST_PUSH);
    assign wr_valid    = busy;
    assign wr_addr     = sp_q - STEP;
    assign wr_data     = push_word;
    assign done        = done_q;
    assign done_esp    = sp_q;
    assign done_ss     = stk_sel_q;
    assign unsupported = unsup_q;

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) - STEP))); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_DONE_ESP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_esp == $past(wr_addr) && $past(wr_valid && wr_ready))); // R7
    AST_TF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !done_eflags[TF_POS]); // R8
    AST_UNSUP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!wr_valid && !done)); // R9
    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !unsupported); // R10
endmodule

// File: tb/sim_exc_frame_seq.sv
`timescale 1ns/100ps
module sim_exc_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  gate_kind = 2'd0;
    logic        err_present = 1'b0;
    logic [31:0] err_code = '0;
    logic        priv_change = 1'b0;
    logic [15:0] cur_ss = '0, cur_cs = '0, new_ss = '0;
    logic [31:0] cur_esp = '0, cur_eflags = '0, cur_eip = '0, new_esp = '0;
    logic        busy, wr_valid, done, unsupported;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr, wr_data, done_esp, done_eflags;
    logic [15:0] done_ss;

    int total = 0;
    int bad = 0;
    int unsup_exp = 0;
    bit finished = 1'b0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] wq[$];
    logic [79:0] dq[$];
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0, prev_data = '0;

    always #2 clk = ~clk;

    exc_frame_seq u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Memory port ready: always ready, or pseudo-random stalls.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready = stall_mode ? lfsr[0] : 1'b1;
    end

    // Monitor: compare stores, completions and rejects against the queues.
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (prev_stall)
                check(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
                      "R6", "hold under stall", {wr_addr, wr_data}, {prev_addr, prev_data});
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            if (wr_valid && wr_ready) begin
                if (wq.size() == 0)
                    check(1'b0, "R10", "unexpected store", {wr_addr, wr_data}, 0);
                else begin
                    logic [63:0] e;
                    e = wq.pop_front();
                    check({wr_addr, wr_data} == e, "R2 R3 R4 R5", "frame word",
                          {wr_addr, wr_data}, e);
                end
            end
            if (done) begin
                if (dq.size() == 0)
                    check(1'b0, "R10", "unexpected done", {done_esp, done_ss, done_eflags}, 0);
                else begin
                    logic [79:0] d;
                    d = dq.pop_front();
                    check(wq.size() == 0, "R7", "done before last store", wq.size(), 0);
                    check({done_esp, done_ss} == d[79:32], "R7", "final esp/ss",
                          {done_esp, done_ss}, d[79:32]);
                    check(done_eflags == d[31:0], "R8", "flags after entry",
                          done_eflags, d[31:0]);
                end
            end
            if (unsupported) begin
                check(unsup_exp > 0 && !wr_valid && !done, "R9", "unsupported pulse",
                      unsup_exp, 1);
                if (unsup_exp > 0) unsup_exp--;
            end
        end else begin
            prev_stall = 1'b0;
        end
    end

    // Driver: present one request and queue the expected results.
    task automatic issue(input logic [1:0] g, input bit pv, input bit ep,
                         input logic [31:0] ec, input logic [15:0] ss,
                         input logic [31:0] sp, input logic [31:0] fl,
                         input logic [15:0] cs, input logic [31:0] ip,
                         input logic [15:0] nss, input logic [31:0] nsp);
        logic [31:0] p;
        logic [31:0] words[$];
        @(negedge clk);
        while (busy) @(negedge clk);
        gate_kind = g; priv_change = pv; err_present = ep; err_code = ec;
        cur_ss = ss; cur_esp = sp; cur_eflags = fl; cur_cs = cs; cur_eip = ip;
        new_ss = nss; new_esp = nsp; req_valid = 1'b1;
        if (g < 2'd2) begin
            p = pv ? nsp : sp;
            if (pv) begin
                words.push_back({16'h0, ss});
                words.push_back(sp);
            end
            words.push_back(fl);
            words.push_back({16'h0, cs});
            words.push_back(ip);
            if (ep) words.push_back(ec);
            foreach (words[i]) begin
                p = p - 32'd4;
                wq.push_back({p, words[i]});
            end
            dq.push_back({p, pv ? nss : ss,
                          (g == 2'd0) ? (fl & ~32'h300) : (fl & ~32'h100)});
        end else begin
            unsup_exp++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 300 && (wq.size() != 0 || dq.size() != 0 || unsup_exp != 0); i++)
            @(negedge clk);
        repeat (2) @(negedge clk);
        check(wq.size() == 0 && dq.size() == 0 && unsup_exp == 0, req, "results pending",
              wq.size() + dq.size() + unsup_exp, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(!wr_valid && !busy && !done && !unsupported, "R1", "reset outputs",
              {wr_valid, busy, done, unsupported}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!wr_valid && !busy && !done && !unsupported, "R1", "idle after reset",
              {wr_valid, busy, done, unsupported}, 0);

        // R2 R8: same-privilege interrupt gate, TF and IF set on entry.
        issue(2'd0, 0, 0, 0, 16'h0010, 32'h0000_8000, 32'h0000_0346, 16'h0008,
              32'h0040_1234, 16'h0, 32'h0);
        drain("R2");
        // R4 R8: same-privilege trap gate with error code, IF must survive.
        issue(2'd1, 0, 1, 32'hDEAD_0004, 16'h0010, 32'h0000_7FF0, 32'h0000_0302,
              16'hFFFF, 32'h0040_2000, 16'h0, 32'h0);
        drain("R4");
        // R3 R5: privilege change through an interrupt gate.
        issue(2'd0, 1, 0, 0, 16'hFFFB, 32'hBFFF_F000, 32'h0000_0202, 16'h001B,
              32'h0804_8000, 16'h0018, 32'h0010_0000);
        drain("R3");
        // R6: stalled memory port, longest frame.
        stall_mode = 1'b1;
        issue(2'd1, 1, 1, 32'h0000_0010, 16'h0023, 32'h7000_0000, 32'hFFFF_FFFF,
              16'h002B, 32'hC000_0001, 16'h0010, 32'h0020_0000);
        drain("R6");
        issue(2'd0, 0, 1, 32'h1234_5678, 16'h0030, 32'h0000_0010, 32'h0000_0100,
              16'h0038, 32'h0000_0042, 16'h0, 32'h0);
        drain("R6");
        for (int k = 0; k < 6; k++) begin
            issue(2'(k % 2), k[1], k[0], 32'hE000_0000 + k, 16'(k + 3),
                  32'h0001_0000 + 32'(k * 64), 32'h0000_0300 ^ 32'(k),
                  16'(k + 8), 32'h5000_0000 + 32'(k), 16'(k + 16), 32'h0002_0000);
            drain("R4");
        end
        stall_mode = 1'b0;
        // R9: task gate and reserved code.
        issue(2'd2, 0, 1, 32'h1, 16'h1, 32'h100, 32'h300, 16'h2, 32'h3, 16'h0, 32'h0);
        drain("R9");
        issue(2'd3, 1, 0, 32'h1, 16'h1, 32'h100, 32'h300, 16'h2, 32'h3, 16'h4, 32'h200);
        drain("R9");
        // R10: requests while busy are ignored.
        stall_mode = 1'b1;
        issue(2'd1, 1, 1, 32'hAAAA_5555, 16'h0040, 32'h0000_9000, 32'h0000_0200,
              16'h0048, 32'h0000_7777, 16'h0050, 32'h0000_A000);
        req_valid = 1'b1; gate_kind = 2'd2;
        @(negedge clk);
        gate_kind = 2'd0; cur_esp = 32'h0000_1000;
        @(negedge clk);
        req_valid = 1'b0;
        drain("R10");
        stall_mode = 1'b0;
        // R11: reset in the middle of a frame.
        issue(2'd0, 1, 1, 32'h0BAD, 16'h0060, 32'h0000_4000, 32'h0000_0300,
              16'h0068, 32'h0000_8888, 16'h0070, 32'h0000_C000);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check(!wr_valid && !busy && !done, "R11", "abandon frame on reset",
              {wr_valid, busy, done}, 0);
        wq.delete();
        dq.delete();
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(!wr_valid && !busy, "R11", "stays idle after reset", {wr_valid, busy}, 0);
        issue(2'd1, 0, 0, 0, 16'h0011, 32'h0000_3000, 32'h0000_0100, 16'h0019,
              32'h0000_9999, 16'h0, 32'h0);
        drain("R11");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog expired act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule